// File: doc/BRIEF.md
# MII Status and Error Signalling Unit

This block sits between the internal decode and encode datapath of an Ethernet PHY and its media-independent interface pins. It derives the collision and carrier-sense indications from transmit enable and receive activity. The receive carrier can come either from both directions of the medium or from receive activity alone. On the receive side it registers the decoded nibble, valid and error flags onto the receive clock. When a receive error is flagged in 100 Mbit/s operation, it replaces the nibble with a code that identifies the class of the error.

On the transmit side, a transmit-error request in 100 Mbit/s operation overwrites the coded 5-bit symbol with a fixed corruption symbol. The unit handles 100 Mbit/s nibble, 10 Mbit/s nibble and 10 Mbit/s serial operation. In serial operation only bit 0 of the data buses carries data, the upper receive bits are released through a per-bit output-enable vector, and the collision pin reports an expired jabber timer. Clock recovery, clock generation and 4B/5B coding lie outside the block. Those clocks and the activity flags arrive as inputs.

Top module: `mii_status_unit`

## Requirements
- R1: Outside serial mode, `col` equals `tx_en AND rx_active` combinationally when `half_duplex` is 1, and is 0 when `half_duplex` is 0.
- R2: In serial mode (`mode_sel` = 2), `col` equals `jabber_expired`, regardless of `half_duplex`, `tx_en` and `rx_active`.
- R3: When neither `crs_sel_reg` nor `crs_sel_pin` is set, `crs` equals `tx_en OR rx_active`, so it stays high throughout a collision.
- R4: When `crs_sel_reg` or `crs_sel_pin` is set, `crs` equals `rx_active` only.
- R5: In 100 Mbit/s mode (`mode_sel` = 0) with `dec_err` high, the next receive clock edge puts an error code on `rxd`. The code is the highest-priority eligible class: code error gives 5h, premature end 4h, link error 3h and packet error 2h, tested in that order.
- R6: A link error is eligible only when `rpt_link_en` is 1, and a packet error only when `rpt_pkt_en` is 1. When no class is eligible, `rxd` takes the decoded nibble.
- R7: When `dec_err` is low, or in either 10 Mbit/s mode (`mode_sel` = 1 or 3 for nibble, 2 for serial), `rxd` takes `dec_nibble` on the next clock edge, whatever the error flags are.
- R8: `rx_dv` and `rx_er` take `dec_dv` and `dec_err` on the next clock edge.
- R9: In 100 Mbit/s mode, `tx_symbol` is 5'b00100 while `tx_en` and `tx_er` are both high. Otherwise it equals `enc_symbol`.
- R10: In 10 Mbit/s nibble mode, `tx_er` has no effect and `tx_symbol` equals `enc_symbol`.
- R11: In serial mode, `rxd_oe` is 4'b0001, `rxd[3:1]` registers 0, `rx_dv` registers 0 and `tx_symbol` carries only bit 0 of `enc_symbol`. In other modes `rxd_oe` is 4'b1111.
- R12: While `rst` is high at a clock edge, `rxd`, `rx_dv` and `rx_er` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 0: 100 Mbit/s nibble, 1 or 3: 10 Mbit/s nibble, 2: 10 Mbit/s serial |
| half_duplex | input | 1 | Half-duplex operation |
| crs_sel_reg | input | 1 | Carrier-select bit from management register |
| crs_sel_pin | input | 1 | Carrier-select strap input |
| tx_en | input | 1 | Transmit enable |
| tx_er | input | 1 | Transmit error request |
| rx_active | input | 1 | Receive medium non-idle |
| jabber_expired | input | 1 | Jabber timer expired |
| dec_nibble | input | 4 | Decoded receive nibble |
| dec_dv | input | 1 | Decoded data valid |
| dec_err | input | 1 | Decoded receive error |
| flag_code | input | 1 | Error class: code error |
| flag_premature | input | 1 | Error class: premature end |
| flag_link | input | 1 | Error class: link error |
| flag_pkt | input | 1 | Error class: packet error |
| rpt_pkt_en | input | 1 | Enable packet-error code |
| rpt_link_en | input | 1 | Enable link-error code |
| enc_symbol | input | 5 | Coded transmit symbol |
| col | output | 1 | Collision / jabber indication |
| crs | output | 1 | Carrier sense |
| tx_symbol | output | 5 | Transmit symbol after error forcing |
| rxd | output | 4 | Registered receive nibble |
| rxd_oe | output | 4 | Per-bit output enable for rxd |
| rx_dv | output | 1 | Registered receive data valid |
| rx_er | output | 1 | Registered receive error |

## Verification
A wrong priority or gating choice in the error selector shows up as a wrong code on `rxd` one receive clock edge after the flags are applied. The bench therefore drives each mix of flags and enables and reads `rxd` at the next falling edge. Faults in the collision, carrier or symbol logic are combinational, so they show at the ports in the same cycle as the stimulus. A mode decode that is off appears at once on `rxd_oe` and `tx_symbol`, and on `rx_dv` one edge later.

// File: rtl/mii_sig_pkg.sv
package mii_sig_pkg;
   localparam logic [1:0] MODE_FAST    = 2'd0;
   localparam logic [1:0] MODE_SLOW    = 2'd1;
   localparam logic [1:0] MODE_SERIAL  = 2'd2;

   typedef enum logic [1:0] {
      ERR_NONE,
      ERR_FIXED,
      ERR_GATED
   } err_kind_e;
endpackage

// File: rtl/mii_col_crs.sv
module mii_col_crs (
   input  logic is_serial,
   input  logic half_duplex,
   input  logic crs_rx_only,
   input  logic tx_en,
   input  logic rx_active,
   input  logic jabber_expired,
   output logic col,
   output logic crs
);
   logic both_busy;

   always_comb begin
      both_busy = tx_en & rx_active;
      if (is_serial)
         col = jabber_expired;
      else
         col = half_duplex & both_busy;
      crs = crs_rx_only ? rx_active : (tx_en | rx_active);
   end
endmodule

// File: rtl/mii_tx_err_force.sv
module mii_tx_err_force #(
   parameter int               SYM_W     = 5,
   parameter logic [SYM_W-1:0] FORCE_SYM = SYM_W'(5'b00100)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             is_fast,
   input  logic             is_serial,
   input  logic             tx_en,
   input  logic             tx_er,
   input  logic [SYM_W-1:0] enc_symbol,
   output logic [SYM_W-1:0] tx_symbol
);
   if (SYM_W < 3) begin : g_bad_sym
      $error("SYM_W must be at least 3");
   end

   always_comb begin
      if (is_fast && tx_en && tx_er)
         tx_symbol = FORCE_SYM;
      else if (is_serial)
         tx_symbol = {{(SYM_W-1){1'b0}}, enc_symbol[0]};
      else
         tx_symbol = enc_symbol;
   end

   AST_TX_FORCE: assert property (@(posedge clk) disable iff (rst)
      (is_fast && tx_en && tx_er) |-> (tx_symbol == FORCE_SYM)); // R9
   AST_TX_SLOW_PASS: assert property (@(posedge clk) disable iff (rst)
      (!is_fast && !is_serial) |-> (tx_symbol == enc_symbol)); // R10
endmodule

// File: rtl/mii_rx_err_mux.sv
module mii_rx_err_mux #(
   parameter int                DATA_W        = 4,
   parameter logic [DATA_W-1:0] CODE_PKT      = DATA_W'(2),
   parameter logic [DATA_W-1:0] CODE_LINK     = DATA_W'(3),
   parameter logic [DATA_W-1:0] CODE_PREMAT   = DATA_W'(4),
   parameter logic [DATA_W-1:0] CODE_CODEERR  = DATA_W'(5)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              is_fast,
   input  logic              is_serial,
   input  logic [DATA_W-1:0] dec_nibble,
   input  logic              dec_dv,
   input  logic              dec_err,
   input  logic              flag_code,
   input  logic              flag_premature,
   input  logic              flag_link,
   input  logic              flag_pkt,
   input  logic              rpt_pkt_en,
   input  logic              rpt_link_en,
   output logic [DATA_W-1:0] rxd,
   output logic              rx_dv,
   output logic              rx_er
);
   import mii_sig_pkg::*;

   localparam int NUM_CLASS = 4;

   if (DATA_W < 3) begin : g_bad_data
      $error("DATA_W must be at least 3 to hold the error codes");
   end

   logic [NUM_CLASS-1:0]        eligible;
   logic [DATA_W-1:0]           code_tab [NUM_CLASS];
   err_kind_e                   kind_tab [NUM_CLASS];
   logic [DATA_W-1:0]           sel_code;
   logic                        sel_hit;
   logic [DATA_W-1:0]           nib_next;
   logic [NUM_CLASS-1:0]        raw_flag;
   logic [NUM_CLASS-1:0]        gate_en;

   // index 0 has the highest priority
   assign raw_flag = {flag_pkt, flag_link, flag_premature, flag_code};
   assign gate_en  = {rpt_pkt_en, rpt_link_en, 1'b1, 1'b1};

   for (genvar k = 0; k < NUM_CLASS; k++) begin : g_class
      always_comb begin
         case (k)
            0:       code_tab[k] = CODE_CODEERR;
            1:       code_tab[k] = CODE_PREMAT;
            2:       code_tab[k] = CODE_LINK;
            default: code_tab[k] = CODE_PKT;
         endcase
         kind_tab[k] = (k < 2) ? ERR_FIXED : ERR_GATED;
         eligible[k] = raw_flag[k] &&
                       ((kind_tab[k] == ERR_FIXED) || gate_en[k]);
      end
   end

   always_comb begin
      sel_code = '0;
      sel_hit  = 1'b0;
      for (int k = NUM_CLASS - 1; k >= 0; k--) begin
         if (eligible[k]) begin
            sel_code = code_tab[k];
            sel_hit  = 1'b1;
         end
      end
      if (is_fast && dec_err && sel_hit)
         nib_next = sel_code;
      else if (is_serial)
         nib_next = {{(DATA_W-1){1'b0}}, dec_nibble[0]};
      else
         nib_next = dec_nibble;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rxd   <= '0;
         rx_dv <= 1'b0;
         rx_er <= 1'b0;
      end else begin
         rxd   <= nib_next;
         rx_dv <= dec_dv & ~is_serial;
         rx_er <= dec_err;
      end
   end

   AST_CODE_ERR_WINS: assert property (@(posedge clk) disable iff (rst)
      (is_fast && dec_err && flag_code) |=> (rxd == CODE_CODEERR)); // R5
   AST_PKT_MASKED: assert property (@(posedge clk) disable iff (rst)
      (is_fast && dec_err && flag_pkt && !flag_code && !flag_premature
       && !flag_link && !rpt_pkt_en) |=> (rxd == $past(dec_nibble))); // R6
   AST_NO_ERR_PASS: assert property (@(posedge clk) disable iff (rst)
      (!dec_err && !is_serial) |=> (rxd == $past(dec_nibble))); // R7
   AST_RXER_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      dec_err |=> rx_er); // R8
   AST_SERIAL_NO_DV: assert property (@(posedge clk) disable iff (rst)
      is_serial |=> !rx_dv); // R11
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!rx_dv && !rx_er && rxd == '0)); // R12
endmodule

// File: rtl/mii_status_unit.sv
module mii_status_unit #(
   parameter int DATA_W = 4,
   parameter int SYM_W  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode_sel,
   input  logic              half_duplex,
   input  logic              crs_sel_reg,
   input  logic              crs_sel_pin,
   input  logic              tx_en,
   input  logic              tx_er,
   input  logic              rx_active,
   input  logic              jabber_expired,
   input  logic [DATA_W-1:0] dec_nibble,
   input  logic              dec_dv,
   input  logic              dec_err,
   input  logic              flag_code,
   input  logic              flag_premature,
   input  logic              flag_link,
   input  logic              flag_pkt,
   input  logic              rpt_pkt_en,
   input  logic              rpt_link_en,
   input  logic [SYM_W-1:0]  enc_symbol,
   output logic              col,
   output logic              crs,
   output logic [SYM_W-1:0]  tx_symbol,
   output logic [DATA_W-1:0] rxd,
   output logic [DATA_W-1:0] rxd_oe,
   output logic              rx_dv,
   output logic              rx_er
);
   import mii_sig_pkg::*;

   logic is_fast;
   logic is_serial;
   logic crs_rx_only;

   assign is_fast     = (mode_sel == MODE_FAST);
   assign is_serial   = (mode_sel == MODE_SERIAL);
   assign crs_rx_only = crs_sel_reg | crs_sel_pin;

   for (genvar b = 0; b < DATA_W; b++) begin : g_oe
      if (b == 0) begin : g_lsb
         assign rxd_oe[b] = 1'b1;
      end else begin : g_upper
         assign rxd_oe[b] = ~is_serial;
      end
   end

   mii_col_crs u_col_crs (
      .is_serial      (is_serial),
      .half_duplex    (half_duplex),
      .crs_rx_only    (crs_rx_only),
      .tx_en          (tx_en),
      .rx_active      (rx_active),
      .jabber_expired (jabber_expired),
      .col            (col),
      .crs            (crs)
   );

   mii_tx_err_force #(.SYM_W(SYM_W)) u_tx_force (
      .clk        (clk),
      .rst        (rst),
      .is_fast    (is_fast),
      .is_serial  (is_serial),
      .tx_en      (tx_en),
      .tx_er      (tx_er),
      .enc_symbol (enc_symbol),
      .tx_symbol  (tx_symbol)
   );

   mii_rx_err_mux #(.DATA_W(DATA_W)) u_rx_mux (
      .clk            (clk),
      .rst            (rst),
      .is_fast        (is_fast),
      .is_serial      (is_serial),
      .dec_nibble     (dec_nibble),
      .dec_dv         (dec_dv),
      .dec_err        (dec_err),
      .flag_code      (flag_code),
      .flag_premature (flag_premature),
      .flag_link      (flag_link),
      .flag_pkt       (flag_pkt),
      .rpt_pkt_en     (rpt_pkt_en),
      .rpt_link_en    (rpt_link_en),
      .rxd            (rxd),
      .rx_dv          (rx_dv),
      .rx_er          (rx_er)
   );

   AST_CRS_HOLDS_COL: assert property (@(posedge clk) disable iff (rst)
      (col && !is_serial && !crs_rx_only) |-> crs); // R3
   AST_CRS_RX_ONLY: assert property (@(posedge clk) disable iff (rst)
      (crs_rx_only && !rx_active) |-> !crs); // R4
   AST_SERIAL_OE: assert property (@(posedge clk) disable iff (rst)
      is_serial |-> (rxd_oe == DATA_W'(1))); // R11
   AST_JABBER_COL: assert property (@(posedge clk) disable iff (rst)
      (is_serial && !jabber_expired) |-> !col); // R2
   AST_FULL_DUPLEX_COL: assert property (@(posedge clk) disable iff (rst)
      (!is_serial && !half_duplex) |-> !col); // R1
endmodule

// File: tb/mii_status_unit_test.sv
module mii_status_unit_test;
   typedef struct packed {
      logic [1:0] mode;
      logic       hd;
      logic       csr;
      logic       csp;
      logic       txen;
      logic       txer;
      logic       rxa;
      logic       jab;
      logic [3:0] nib;
      logic       dv;
      logic       err;
      logic       fc;
      logic       fp;
      logic       fl;
      logic       fk;
      logic       rpk;
      logic       rpl;
      logic [4:0] sym;
      logic       x_col;
      logic       x_crs;
      logic [4:0] x_sym;
      logic [3:0] x_rxd;
      logic       x_dv;
      logic       x_er;
      logic [3:0] x_oe;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      // R3 R7: transmit only, half duplex
      '{2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'hA,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h1E,
        1'b0,1'b1,5'h1E,4'hA,1'b1,1'b0,4'hF},
      // R1 R3: collision
      '{2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,4'h3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h0A,
        1'b1,1'b1,5'h0A,4'h3,1'b1,1'b0,4'hF},
      // R1: full duplex no collision
      '{2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,4'h4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h15,
        1'b0,1'b1,5'h15,4'h4,1'b0,1'b0,4'hF},
      // R4: register select, tx only
      '{2'd0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h0F,
        1'b0,1'b0,5'h0F,4'h1,1'b0,1'b0,4'hF},
      // R4: pin select, rx only
      '{2'd0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,4'h2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h0F,
        1'b0,1'b1,5'h0F,4'h2,1'b1,1'b0,4'hF},
      // R5: all classes, code error wins
      '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'h9,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,5'h01,
        1'b0,1'b1,5'h01,4'h5,1'b1,1'b1,4'hF},
      // R5: premature wins over link, packet
      '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'h9,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,5'h01,
        1'b0,1'b1,5'h01,4'h4,1'b1,1'b1,4'hF},
      // R5: link wins over packet
      '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'h9,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,5'h01,
        1'b0,1'b1,5'h01,4'h3,1'b1,1'b1,4'hF},
      // R5 R6: link masked, packet enabled
      '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'h9,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,5'h01,
        1'b0,1'b1,5'h01,4'h2,1'b1,1'b1,4'hF},
      // R6: link only, disabled
      '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'h7,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,5'h01,
        1'b0,1'b1,5'h01,4'h7,1'b1,1'b1,4'hF},
      // R6: packet only, disabled
      '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'h6,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,5'h01,
        1'b0,1'b1,5'h01,4'h6,1'b1,1'b1,4'hF},
      // R9: forced symbol
      '{2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h1E,
        1'b0,1'b1,5'h04,4'h0,1'b0,1'b0,4'hF},
      // R10 R7: 10 nibble, tx_er ignored, no error code
      '{2'd1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h9,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,5'h1E,
        1'b0,1'b1,5'h1E,4'h9,1'b1,1'b1,4'hF},
      // R11 R2: serial, collision pin tracks jabber only
      '{2'd2,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,4'hF,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h1F,
        1'b0,1'b1,5'h01,4'h1,1'b0,1'b0,4'h1},
      // R2: serial, jabber expired
      '{2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'hE,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h1E,
        1'b1,1'b0,5'h00,4'h0,1'b0,1'b0,4'h1},
      // R9: tx_er without tx_en
      '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'h5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,5'h1E,
        1'b0,1'b0,5'h1E,4'h5,1'b0,1'b0,4'hF}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] mode_sel = '0;
   logic       half_duplex = 0, crs_sel_reg = 0, crs_sel_pin = 0;
   logic       tx_en = 0, tx_er = 0, rx_active = 0, jabber_expired = 0;
   logic [3:0] dec_nibble = '0;
   logic       dec_dv = 0, dec_err = 0;
   logic       flag_code = 0, flag_premature = 0, flag_link = 0, flag_pkt = 0;
   logic       rpt_pkt_en = 0, rpt_link_en = 0;
   logic [4:0] enc_symbol = '0;
   logic       col, crs, rx_dv, rx_er;
   logic [4:0] tx_symbol;
   logic [3:0] rxd, rxd_oe;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mii_status_unit uut (
      .clk(clk), .rst(rst), .mode_sel(mode_sel), .half_duplex(half_duplex),
      .crs_sel_reg(crs_sel_reg), .crs_sel_pin(crs_sel_pin), .tx_en(tx_en),
      .tx_er(tx_er), .rx_active(rx_active), .jabber_expired(jabber_expired),
      .dec_nibble(dec_nibble), .dec_dv(dec_dv), .dec_err(dec_err),
      .flag_code(flag_code), .flag_premature(flag_premature),
      .flag_link(flag_link), .flag_pkt(flag_pkt), .rpt_pkt_en(rpt_pkt_en),
      .rpt_link_en(rpt_link_en), .enc_symbol(enc_symbol), .col(col),
      .crs(crs), .tx_symbol(tx_symbol), .rxd(rxd), .rxd_oe(rxd_oe),
      .rx_dv(rx_dv), .rx_er(rx_er)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      mode_sel = v.mode; half_duplex = v.hd; crs_sel_reg = v.csr; crs_sel_pin = v.csp;
      tx_en = v.txen; tx_er = v.txer; rx_active = v.rxa; jabber_expired = v.jab;
      dec_nibble = v.nib; dec_dv = v.dv; dec_err = v.err;
      flag_code = v.fc; flag_premature = v.fp; flag_link = v.fl; flag_pkt = v.fk;
      rpt_pkt_en = v.rpk; rpt_link_en = v.rpl; enc_symbol = v.sym;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state with valid and error requested
      dec_dv = 1; dec_err = 1; dec_nibble = 4'hC;
      @(negedge clk);
      check("R12 rxd in reset", 8'(rxd), 8'h0);
      check("R12 rx_dv in reset", 8'(rx_dv), 8'h0);
      check("R12 rx_er in reset", 8'(rx_er), 8'h0);
      rst = 0;
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         @(negedge clk);
         check("R1/R2 col", 8'(col), 8'(VEC[i].x_col));
         check("R3/R4 crs", 8'(crs), 8'(VEC[i].x_crs));
         check("R9/R10/R11 tx_symbol", 8'(tx_symbol), 8'(VEC[i].x_sym));
         check("R5/R6/R7/R11 rxd", 8'(rxd), 8'(VEC[i].x_rxd));
         check("R8/R11 rx_dv", 8'(rx_dv), 8'(VEC[i].x_dv));
         check("R8 rx_er", 8'(rx_er), 8'(VEC[i].x_er));
         check("R11 rxd_oe", 8'(rxd_oe), 8'(VEC[i].x_oe));
      end
      // R12: reset in mid-stream clears an error code already shown
      apply(VEC[5]);
      @(negedge clk);
      check("R5 code before reset", 8'(rxd), 8'h5);
      rst = 1;
      @(negedge clk);
      check("R12 rxd after reset", 8'(rxd), 8'h0);
      check("R12 rx_er after reset", 8'(rx_er), 8'h0);
      check("R12 rx_dv after reset", 8'(rx_dv), 8'h0);
      rst = 0;
      // R7: mode 3 acts as 10 Mbit/s nibble, no error code
      apply(VEC[5]);
      mode_sel = 2'd3;
      @(negedge clk);
      check("R7 mode3 passthrough", 8'(rxd), 8'h9);
      check("R11 mode3 oe", 8'(rxd_oe), 8'hF);
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule